// File: doc/BRIEF.md
# Offset calibration and watchdog controller

This block owns the 10-bit code that drives an offset-cancelling DAC in front of a magnetic-edge comparator. After reset it holds the switching output locked and finds a starting code by successive approximation. It resolves one bit per decimated-sample strobe, starting at the most significant bit, and uses a single compare bit that says whether the signal sits above the present DAC level.

Once the search ends, the block enters running mode and releases the output lock. From then on it refines the code at comparator edges, using the most recent minimum and maximum peak values captured elsewhere. The correction is the peak sum less its midpoint, shifted by the current gain position. Several rules guard the update: a hysteretic fine-calibration band, a filter that demands two large corrections in the same direction, per-edge lockouts after gain changes and after updates, and a rule that ties the correction's sign to the edge direction.

A supervisor watches the output-switch events. If the output stays silent too long, it issues a reset that restarts the search. If too many switches pass without a new peak, it asks for a lower gain.

Top module: `ofs_cal_ctrl`

## Requirements
- R1: After reset, `ofs_code` is 0x200, `running` is 0, `out_lock` is 1, and `wd_reset` and `gain_dec` are 0.
- R2: While not running, each `sample_stb` decides one code bit, from bit 9 down to bit 0. The bit stays 1 if `above_dac` is 1 and becomes 0 otherwise, and the next lower bit is set as the new trial. The strobe on bit 0 sets `running`=1 and `out_lock`=0 on the next cycle. Without a strobe the code does not change.
- R3: The correction C is (`pk_min` + `pk_max` − 256). It is shifted left by (`gain_pos` − 3) when `gain_pos` ≥ 3, and arithmetically right by (3 − `gain_pos`) otherwise.
- R4: An applied step saturates the code at 0 and at 1023.
- R5: Let A = `pk_max` − `pk_min`. Fine mode is set when A < 8 and cleared when A > 16; otherwise it is kept. With A < 8 the code is held. In fine mode with 8 ≤ A ≤ 16, the step is ±1 toward the sign of C.
- R6: Outside fine mode the full C is applied only if |C| > 8, the previous qualified edge also had |C| > 8, and both had the same sign.
- R7: A positive step is applied only on an edge with `cmp_rise`=1, and a negative step only on an edge with `cmp_rise`=0.
- R8: After `gain_chg`, the next two comparator edges are ignored. After an applied step, the next one edge is ignored.
- R9: An edge with neither `min_ok` nor `max_ok` changes nothing. The first qualified edge after each search applies no step.
- R10: After 2^WD_BITS consecutive running cycles without `out_switch`, `wd_reset` pulses for one cycle. In that same cycle the code returns to 0x200 and `out_lock` rises, so the search restarts.
- R11: `gain_dec` pulses on the 16th `out_switch` since the last `peak_new`. A `peak_new` in the same cycle as a switch clears the count with no pulse.
- R12: When the watchdog expires in the same cycle as a qualified comparator edge, the restart wins and no step is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sample_stb | input | 1 | Decimated sample strobe; paces the search |
| above_dac | input | 1 | Signal is above the current DAC level |
| pk_min | input | 8 | Latest minimum peak |
| pk_max | input | 8 | Latest maximum peak |
| min_ok | input | 1 | Minimum peak is valid |
| max_ok | input | 1 | Maximum peak is valid |
| gain_pos | input | 3 | Current amplifier gain position |
| gain_chg | input | 1 | Gain position changed (pulse) |
| cmp_edge | input | 1 | Comparator edge strobe |
| cmp_rise | input | 1 | Edge direction, 1 = rising |
| out_switch | input | 1 | Output switched this cycle |
| peak_new | input | 1 | A new min or max was identified |
| ofs_code | output | 10 | Offset DAC code |
| running | output | 1 | Search done, running mode |
| out_lock | output | 1 | Hold the switching output |
| wd_reset | output | 1 | Watchdog restart pulse |
| gain_dec | output | 1 | Request one lower gain step |

## Verification
Two functions can land in the same cycle: watchdog expiry and a qualified comparator edge that carries a large correction. The bench provokes this by issuing one output switch, waiting exactly one cycle short of the expiry, and then presenting the edge without a switch. The result is correct when the watchdog pulse appears together with code 0x200 and the output lock, and no trace of the step remains. A second collision, a peak report in the same cycle as the switch that would complete the count, is judged by the absence of a gain-decrement pulse.

// File: rtl/ofs_cal_pkg.sv
package ofs_cal_pkg;
    typedef enum logic {
        PH_SEARCH = 1'b0,
        PH_RUN    = 1'b1
    } phase_e;
endpackage

// File: rtl/ofs_step_calc.sv
module ofs_step_calc #(
    parameter int PEAK_W   = 8,
    parameter int GAIN_W   = 3,
    parameter int GAIN_REF = 3,
    parameter int CORR_W   = 14,
    parameter int FINE_LO  = 8,
    parameter int FINE_HI  = 16,
    parameter int BIG_TH   = 8
) (
    input  logic [PEAK_W-1:0]        pk_min,
    input  logic [PEAK_W-1:0]        pk_max,
    input  logic [GAIN_W-1:0]        gain_pos,
    input  logic                     fine_q,
    input  logic                     prev_big,
    input  logic                     prev_neg,
    input  logic                     rise,
    output logic signed [CORR_W-1:0] step,
    output logic                     dir_ok,
    output logic                     fine_d,
    output logic                     cur_big,
    output logic                     cur_neg
);
    localparam int SUM_W = PEAK_W + 2;
    localparam int AMP_W = PEAK_W + 1;

    logic signed [SUM_W-1:0]  diff;
    logic signed [CORR_W-1:0] wide, corr, mag;
    logic signed [AMP_W-1:0]  amp;
    logic                     lt_lo, gt_hi;

    always_comb begin
        diff = $signed({2'b00, pk_min}) + $signed({2'b00, pk_max})
             - $signed(SUM_W'(1 << PEAK_W));
        wide = CORR_W'(diff);
        if (gain_pos >= GAIN_W'(GAIN_REF))
            corr = wide <<< (gain_pos - GAIN_W'(GAIN_REF));
        else
            corr = wide >>> (GAIN_W'(GAIN_REF) - gain_pos);

        amp   = $signed({1'b0, pk_max}) - $signed({1'b0, pk_min});
        lt_lo = amp < $signed(AMP_W'(FINE_LO));
        gt_hi = amp > $signed(AMP_W'(FINE_HI));
        fine_d = lt_lo ? 1'b1 : (gt_hi ? 1'b0 : fine_q);

        cur_neg = corr[CORR_W-1];
        mag     = cur_neg ? -corr : corr;
        cur_big = mag > $signed(CORR_W'(BIG_TH));

        if (lt_lo)
            step = '0;
        else if (fine_d)
            step = cur_neg ? '1 : ((corr != '0) ? CORR_W'(1) : '0);
        else if (cur_big && prev_big && (cur_neg == prev_neg))
            step = corr;
        else
            step = '0;

        dir_ok = (step != '0) && (step[CORR_W-1] ? !rise : rise);
    end
endmodule

// File: rtl/ofs_supervisor.sv
module ofs_supervisor #(
    parameter int WD_BITS    = 20,
    parameter int DEC_EVENTS = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic out_switch,
    input  logic peak_new,
    output logic fire,
    output logic wd_reset,
    output logic gain_dec
);
    localparam int GC_W = $clog2(DEC_EVENTS);

    typedef struct packed {
        logic [WD_BITS-1:0] wcnt;
        logic [GC_W-1:0]    gcnt;
        logic               wd;
        logic               dec;
    } sup_t;

    sup_t r_q, r_d;

    assign fire     = run && !out_switch && (r_q.wcnt == '1);
    assign wd_reset = r_q.wd;
    assign gain_dec = r_q.dec;

    always_comb begin
        r_d     = r_q;
        r_d.wd  = fire;
        r_d.dec = 1'b0;
        if (!run || fire) begin
            r_d.wcnt = '0;
            r_d.gcnt = '0;
        end else begin
            r_d.wcnt = out_switch ? '0 : r_q.wcnt + 1'b1;
            if (peak_new)
                r_d.gcnt = '0;
            else if (out_switch) begin
                if (r_q.gcnt == GC_W'(DEC_EVENTS - 1)) begin
                    r_d.dec  = 1'b1;
                    r_d.gcnt = '0;
                end else begin
                    r_d.gcnt = r_q.gcnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assert_wd_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |=> !wd_reset);
    assert_dec_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gain_dec |-> $past(out_switch));
    assert_dec_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        gain_dec |=> !gain_dec);
endmodule

// File: rtl/ofs_cal_ctrl.sv
module ofs_cal_ctrl #(
    parameter int CODE_W     = 10,
    parameter int PEAK_W     = 8,
    parameter int GAIN_W     = 3,
    parameter int GAIN_REF   = 3,
    parameter int WD_BITS    = 20,
    parameter int DEC_EVENTS = 16,
    parameter int FINE_LO    = 8,
    parameter int FINE_HI    = 16,
    parameter int BIG_TH     = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sample_stb,
    input  logic              above_dac,
    input  logic [PEAK_W-1:0] pk_min,
    input  logic [PEAK_W-1:0] pk_max,
    input  logic              min_ok,
    input  logic              max_ok,
    input  logic [GAIN_W-1:0] gain_pos,
    input  logic              gain_chg,
    input  logic              cmp_edge,
    input  logic              cmp_rise,
    input  logic              out_switch,
    input  logic              peak_new,
    output logic [CODE_W-1:0] ofs_code,
    output logic              running,
    output logic              out_lock,
    output logic              wd_reset,
    output logic              gain_dec
);
    import ofs_cal_pkg::*;

    localparam int IDX_W    = $clog2(CODE_W);
    localparam int MAX_UP   = (1 << GAIN_W) - 1 - GAIN_REF;
    localparam int CORR_W   = PEAK_W + 2 + MAX_UP;
    localparam int ACC_W    = ((CORR_W > CODE_W) ? CORR_W : CODE_W) + 2;
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);

    typedef struct packed {
        phase_e            phase;
        logic [CODE_W-1:0] code;
        logic [IDX_W-1:0]  bit_idx;
        logic [1:0]        blk;
        logic              fine;
        logic              pbig;
        logic              pneg;
        logic              first;
    } cal_t;

    cal_t r_q, r_d;

    logic signed [CORR_W-1:0] step;
    logic                     dir_ok, fine_d, cur_big, cur_neg, wd_fire;
    logic signed [ACC_W-1:0]  acc;
    logic [CODE_W-1:0]        sat_code;

    ofs_step_calc #(
        .PEAK_W(PEAK_W), .GAIN_W(GAIN_W), .GAIN_REF(GAIN_REF), .CORR_W(CORR_W),
        .FINE_LO(FINE_LO), .FINE_HI(FINE_HI), .BIG_TH(BIG_TH)
    ) u_step (
        .pk_min(pk_min), .pk_max(pk_max), .gain_pos(gain_pos),
        .fine_q(r_q.fine), .prev_big(r_q.pbig), .prev_neg(r_q.pneg),
        .rise(cmp_rise), .step(step), .dir_ok(dir_ok), .fine_d(fine_d),
        .cur_big(cur_big), .cur_neg(cur_neg)
    );

    ofs_supervisor #(.WD_BITS(WD_BITS), .DEC_EVENTS(DEC_EVENTS)) u_sup (
        .clk(clk), .rst_n(rst_n), .run(r_q.phase == PH_RUN),
        .out_switch(out_switch), .peak_new(peak_new), .fire(wd_fire),
        .wd_reset(wd_reset), .gain_dec(gain_dec)
    );

    always_comb begin
        acc = $signed({{(ACC_W-CODE_W){1'b0}}, r_q.code}) + $signed(ACC_W'(step));
        if (acc < 0)
            sat_code = '0;
        else if (acc > $signed({{(ACC_W-CODE_W){1'b0}}, {CODE_W{1'b1}}}))
            sat_code = '1;
        else
            sat_code = acc[CODE_W-1:0];

        r_d = r_q;
        if (wd_fire) begin
            r_d.phase   = PH_SEARCH;
            r_d.code    = MID;
            r_d.bit_idx = IDX_W'(CODE_W - 1);
            r_d.blk     = '0;
            r_d.fine    = 1'b0;
            r_d.pbig    = 1'b0;
            r_d.pneg    = 1'b0;
            r_d.first   = 1'b1;
        end else if (r_q.phase == PH_SEARCH) begin
            if (sample_stb) begin
                if (!above_dac) r_d.code[r_q.bit_idx] = 1'b0;
                if (r_q.bit_idx != '0) begin
                    r_d.code[r_q.bit_idx - 1'b1] = 1'b1;
                    r_d.bit_idx = r_q.bit_idx - 1'b1;
                end else begin
                    r_d.phase = PH_RUN;
                    r_d.first = 1'b1;
                end
            end
        end else begin
            if (cmp_edge) begin
                if (r_q.blk != '0) begin
                    r_d.blk = r_q.blk - 1'b1;
                end else if (min_ok || max_ok) begin
                    r_d.fine = fine_d;
                    r_d.pbig = cur_big;
                    r_d.pneg = cur_neg;
                    if (r_q.first) begin
                        r_d.first = 1'b0;
                    end else if (dir_ok) begin
                        r_d.code = sat_code;
                        r_d.blk  = 2'd1;
                    end
                end
            end
            if (gain_chg) r_d.blk = 2'd2;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q         <= '0;
            r_q.phase   <= PH_SEARCH;
            r_q.code    <= MID;
            r_q.bit_idx <= IDX_W'(CODE_W - 1);
            r_q.first   <= 1'b1;
        end else begin
            r_q <= r_d;
        end
    end

    assign ofs_code = r_q.code;
    assign running  = (r_q.phase == PH_RUN);
    assign out_lock = !running;

    assert_search_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !sample_stb) |=> $stable(ofs_code));
    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmp_edge && !wd_fire && ({1'b0, pk_max} < {1'b0, pk_min} + 9'd8))
        |=> $stable(ofs_code));
    assert_fall_down_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmp_edge && !cmp_rise && !wd_fire) |=> (ofs_code <= $past(ofs_code)));
    assert_rise_up_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmp_edge && cmp_rise && !wd_fire) |=> (ofs_code >= $past(ofs_code)));
    assert_blocked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmp_edge && (r_q.blk != 2'd0) && !wd_fire) |=> $stable(ofs_code));
    assert_no_peaks_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (running && cmp_edge && !min_ok && !max_ok && !wd_fire) |=> $stable(ofs_code));
    assert_restart_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wd_reset |-> (out_lock && (ofs_code == MID)));
endmodule

// File: tb/sim_ofs_cal_ctrl.sv
module sim_ofs_cal_ctrl;
    localparam int WDB = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic rst_n, sample_stb, above_dac, min_ok, max_ok, gain_chg;
    logic cmp_edge, cmp_rise, out_switch, peak_new;
    logic [7:0] pk_min, pk_max;
    logic [2:0] gain_pos;
    logic [9:0] ofs_code;
    logic running, out_lock, wd_reset, gain_dec;

    ofs_cal_ctrl #(.WD_BITS(WDB)) u0 (
        .clk(clk), .rst_n(rst_n), .sample_stb(sample_stb), .above_dac(above_dac),
        .pk_min(pk_min), .pk_max(pk_max), .min_ok(min_ok), .max_ok(max_ok),
        .gain_pos(gain_pos), .gain_chg(gain_chg), .cmp_edge(cmp_edge),
        .cmp_rise(cmp_rise), .out_switch(out_switch), .peak_new(peak_new),
        .ofs_code(ofs_code), .running(running), .out_lock(out_lock),
        .wd_reset(wd_reset), .gain_dec(gain_dec)
    );

    int n_chk = 0, n_bad = 0;
    bit done = 0;
    string tag = "R1";

    int m_code, m_bit, m_blk, m_wcnt, m_gcnt;
    bit m_run, m_fine, m_pbig, m_pneg, m_first, m_wd, m_gdec;

    task automatic chk(string t, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", t, act, exp);
        end
    endtask

    function automatic int corr_of(int mn, int mx, int g);
        int d = mn + mx - 256;
        if (g >= 3) return d * (1 << (g - 3));
        return d >>> (3 - g);
    endfunction

    task automatic model_init();
        m_run = 0; m_code = 512; m_bit = 9; m_blk = 0; m_wcnt = 0; m_gcnt = 0;
        m_fine = 0; m_pbig = 0; m_pneg = 0; m_first = 1; m_wd = 0; m_gdec = 0;
    endtask

    task automatic model_update();
        bit fire, big, neg;
        int c, amp, st, fn;
        fire = m_run && !out_switch && (m_wcnt == (1 << WDB) - 1);
        m_wd = fire; m_gdec = 0;
        if (fire) begin
            model_init();
            m_wd = 1;
        end else if (!m_run) begin
            m_wcnt = 0; m_gcnt = 0;
            if (sample_stb) begin
                if (!above_dac) m_code = m_code & ~(1 << m_bit);
                if (m_bit > 0) begin
                    m_bit--;
                    m_code = m_code | (1 << m_bit);
                end else begin
                    m_run = 1; m_first = 1;
                end
            end
        end else begin
            if (out_switch) m_wcnt = 0; else m_wcnt++;
            if (peak_new) m_gcnt = 0;
            else if (out_switch) begin
                if (m_gcnt == 15) begin m_gdec = 1; m_gcnt = 0; end
                else m_gcnt++;
            end
            if (cmp_edge) begin
                if (m_blk > 0) m_blk--;
                else if (min_ok || max_ok) begin
                    c   = corr_of(pk_min, pk_max, gain_pos);
                    amp = int'(pk_max) - int'(pk_min);
                    if (amp < 8) fn = 1; else if (amp > 16) fn = 0; else fn = m_fine;
                    big = (c > 8) || (c < -8);
                    neg = c < 0;
                    if (amp < 8) st = 0;
                    else if (fn == 1) st = (c > 0) ? 1 : ((c < 0) ? -1 : 0);
                    else if (big && m_pbig && (neg == m_pneg)) st = c;
                    else st = 0;
                    m_fine = fn[0]; m_pbig = big; m_pneg = neg;
                    if (m_first) m_first = 0;
                    else if (st != 0 && ((st > 0) == cmp_rise)) begin
                        m_code += st;
                        if (m_code < 0) m_code = 0;
                        if (m_code > 1023) m_code = 1023;
                        m_blk = 1;
                    end
                end
            end
            if (gain_chg) m_blk = 2;
        end
    endtask

    task automatic cyc();
        model_update();
        @(posedge clk);
        #2;
        chk({tag, " code"}, int'(ofs_code), m_code);
        chk({tag, " running"}, int'(running), int'(m_run));
        chk({tag, " lock"}, int'(out_lock), int'(!m_run));
        chk({tag, " wd_reset"}, int'(wd_reset), int'(m_wd));
        chk({tag, " gain_dec"}, int'(gain_dec), int'(m_gdec));
        sample_stb = 0; cmp_edge = 0; gain_chg = 0; out_switch = 0; peak_new = 0;
    endtask

    task automatic do_sar(int target);
        tag = "R2 search";
        while (!running) begin
            above_dac = (target >= int'(ofs_code));
            sample_stb = 1;
            cyc();
            cyc();
        end
        chk("R2 search result", int'(ofs_code), target);
    endtask

    task automatic edge_ev(bit rise, int mn, int mx, int g, bit vmin = 1, bit vmax = 1);
        pk_min = 8'(mn); pk_max = 8'(mx); gain_pos = 3'(g);
        min_ok = vmin; max_ok = vmax;
        cmp_edge = 1; cmp_rise = rise; out_switch = 1;
        cyc();
    endtask

    task automatic wd_expire(string t);
        int n = 0;
        tag = t;
        out_switch = 1;
        cyc();
        for (int i = 1; i <= (1 << WDB) + 4 && n == 0; i++) begin
            cyc();
            if (wd_reset) n = i;
        end
        chk({t, " quiet span"}, n, 1 << WDB);
        chk({t, " lock after restart"}, int'(out_lock), 1);
        chk({t, " code after restart"}, int'(ofs_code), 512);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd7));
        rst_n = 0; sample_stb = 0; above_dac = 0; min_ok = 0; max_ok = 0;
        gain_chg = 0; cmp_edge = 0; cmp_rise = 0; out_switch = 0; peak_new = 0;
        pk_min = 0; pk_max = 0; gain_pos = 3'd3;
        model_init();
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        chk("R1 reset code", int'(ofs_code), 512);
        chk("R1 reset running", int'(running), 0);
        chk("R1 reset lock", int'(out_lock), 1);
        chk("R1 reset wd", int'(wd_reset), 0);
        chk("R1 reset dec", int'(gain_dec), 0);

        do_sar(677);
        tag = "R9 first edge";
        edge_ev(1, 100, 180, 3); chk("R9 first edge skipped", int'(ofs_code), 677);
        tag = "R6 full step";
        edge_ev(1, 100, 180, 3); chk("R6 full step", int'(ofs_code), 701);
        tag = "R8 post-update";
        edge_ev(1, 100, 180, 3); chk("R8 edge after update", int'(ofs_code), 701);
        edge_ev(1, 100, 180, 3); chk("R3 gain3 step", int'(ofs_code), 725);
        edge_ev(0, 100, 180, 3);
        tag = "R7 direction";
        edge_ev(0, 100, 180, 3); chk("R7 up on falling", int'(ofs_code), 725);

        tag = "R8 gain change";
        gain_pos = 3'd4; gain_chg = 1; cyc();
        edge_ev(1, 100, 180, 4); chk("R8 gain edge1", int'(ofs_code), 725);
        edge_ev(1, 100, 180, 4); chk("R8 gain edge2", int'(ofs_code), 725);
        edge_ev(1, 100, 180, 4); chk("R3 gain4 doubled", int'(ofs_code), 773);
        edge_ev(1, 100, 180, 4);
        tag = "R6 filter";
        edge_ev(0, 60, 150, 4); chk("R6 sign flip held", int'(ofs_code), 773);
        edge_ev(0, 60, 150, 4); chk("R6 same sign applied", int'(ofs_code), 681);

        tag = "R5 fine";
        edge_ev(1, 130, 136, 4);
        edge_ev(1, 130, 136, 4); chk("R5 dead band", int'(ofs_code), 681);
        edge_ev(1, 128, 140, 4); chk("R5 unit step", int'(ofs_code), 682);
        edge_ev(1, 124, 144, 4);
        edge_ev(1, 124, 144, 4); chk("R5 leave fine", int'(ofs_code), 706);
        tag = "R9 invalid";
        edge_ev(1, 100, 180, 4);
        edge_ev(1, 100, 180, 4, 0, 0); chk("R9 no valid peak", int'(ofs_code), 706);

        tag = "R11 gain dec";
        out_switch = 1; peak_new = 1; cyc();
        repeat (15) begin out_switch = 1; cyc(); end
        out_switch = 1; peak_new = 1; cyc();
        chk("R11 peak same cycle", int'(gain_dec), 0);
        repeat (15) begin out_switch = 1; cyc(); end
        chk("R11 before 16th", int'(gain_dec), 0);
        out_switch = 1; cyc();
        chk("R11 on 16th", int'(gain_dec), 1);

        wd_expire("R10 watchdog");

        do_sar(1015);
        tag = "R4 upper";
        edge_ev(1, 140, 200, 6);
        edge_ev(1, 140, 200, 6); chk("R4 clip high", int'(ofs_code), 1023);
        wd_expire("R10 watchdog 2");
        do_sar(5);
        tag = "R4 lower";
        edge_ev(0, 40, 60, 6);
        edge_ev(0, 40, 60, 6); chk("R4 clip low", int'(ofs_code), 0);
        edge_ev(0, 40, 60, 6);
        edge_ev(0, 40, 60, 6); chk("R4 stay low", int'(ofs_code), 0);
        wd_expire("R10 watchdog 3");

        do_sar(400);
        tag = "R12 collision";
        edge_ev(1, 100, 180, 3);
        out_switch = 1; cyc();
        repeat ((1 << WDB) - 1) cyc();
        pk_min = 8'd100; pk_max = 8'd180; min_ok = 1; max_ok = 1;
        cmp_edge = 1; cmp_rise = 1; out_switch = 0;
        cyc();
        chk("R12 wd pulse", int'(wd_reset), 1);
        chk("R12 code restarted", int'(ofs_code), 512);
        chk("R12 lock", int'(out_lock), 1);

        do_sar(300);
        tag = "R3 R5 R6 R7 R8 random";
        for (int k = 0; k < 600; k++) begin
            int c, h, mn, mx;
            if ($urandom_range(0, 7) == 0) begin
                gain_pos = 3'($urandom_range(0, 6)); gain_chg = 1; cyc();
            end
            c = 128 + $urandom_range(0, 80) - 40;
            case ($urandom_range(0, 5))
                0: h = 1; 1: h = 3; 2: h = 5; 3: h = 7; 4: h = 20; default: h = 60;
            endcase
            mn = c - h; mx = c + h + $urandom_range(0, 2);
            if (mn < 0) mn = 0;
            if (mx > 255) mx = 255;
            peak_new = ($urandom_range(0, 3) == 0);
            edge_ev(1'($urandom_range(0, 1)), mn, mx, int'(gain_pos),
                    ($urandom_range(0, 7) != 0), ($urandom_range(0, 7) != 0));
            repeat ($urandom_range(0, 2)) cyc();
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule